// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a small group of input pins and turns selected activity on them into a single interrupt request. Each pin has its own detection setup. It can detect a change of level on both edges. It can detect a change of level on one chosen edge. It can also detect a steady level of a chosen polarity. Every detection sets a sticky bit in a raw status vector, and the bit stays set until software clears it.

Software configures the block through register-bus writes to fixed offsets. A per-pin enable selects which raw bits are allowed to reach the interrupt line. The pins arrive already synchronous to the block clock. A per-pin direction input marks pins that are driven outward; edges on those pins are ignored.

Top module: `pin_event_irq`

## Requirements
- R1: Writes with `wr_en` high land at these offsets: level-select 0x404, any-edge 0x408, polarity 0x40C, enable 0x410, clear 0x41C. The new value takes effect for detection from the following clock. Writes to any other offset change nothing.
- R2: For a pin whose level-select bit is 0, the pin uses edge detection. For a pin whose level-select bit is 1, the pin uses level detection.
- R3: In edge mode with the any-edge bit set, a pin value that differs from its value in the previous cycle sets the raw status bit at the next clock.
- R4: In edge mode with the any-edge bit clear, a change sets the raw bit only when the new level equals the polarity bit (1 = rising, 0 = falling). A change to the other level leaves the raw bit unchanged.
- R5: In level mode, the raw bit is set on every clock where the pin level equals the polarity bit, whatever the direction bit. A clear therefore has no lasting effect while the level persists.
- R6: For a pin whose direction bit is 1, edges on that pin never set its raw bit.
- R7: `masked_status` equals raw status AND enable. `irq` is high exactly when `masked_status` is non-zero.
- R8: Writing ones to the clear offset clears those raw bits at the next clock. If a detection sets the same bit in the same cycle, the set takes priority. Apart from a clear, raw bits never fall.
- R9: A synchronous active-low reset zeroes all configuration, the raw status and the previous-pin register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | N_PINS | Current pin levels, already synchronous |
| pin_dir | input | N_PINS | Per-pin direction; 1 = driven outward |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | N_PINS | Register write data |
| raw_status | output | N_PINS | Sticky detection bits |
| masked_status | output | N_PINS | Raw status gated by the enable register |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle:
- Raw bits never drop without a clear to that bit.
- A level-mode pin whose level matched in the previous cycle always shows its bit set.
- An output-direction pin in edge mode never gains a bit.
- A single-edge pin never gains a bit on the wrong polarity.
- An enable write is reflected in the masked status at once.

The bench scenarios are needed for the remaining behaviour:
- The exact edge sequences on rising, falling and both-edge pins.
- A clear written in the same cycle as a new detection.
- A level that survives repeated clears and then drops.
- The reset state.

// File: rtl/pin_evt_pkg.sv
// Package: shared register offsets and bus types for the pin event
// interrupt detector. Assumes a 12-bit byte offset on the register bus.
package pin_evt_pkg;

    localparam int ADDR_W = 12;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t OFS_LEVEL  = 12'h404;
    localparam reg_addr_t OFS_ANY    = 12'h408;
    localparam reg_addr_t OFS_POL    = 12'h40C;
    localparam reg_addr_t OFS_ENABLE = 12'h410;
    localparam reg_addr_t OFS_CLEAR  = 12'h41C;

endpackage

// File: rtl/pin_evt_cfg.sv
// Module: configuration register file. Holds the level-select, any-edge,
// polarity and enable vectors, and decodes writes to the clear offset
// into a one-cycle clear vector. Assumes single-cycle write strobes.
module pin_evt_cfg
    import pin_evt_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_addr_t         wr_addr,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] cfg_level,
    output logic [N_PINS-1:0] cfg_any,
    output logic [N_PINS-1:0] cfg_pol,
    output logic [N_PINS-1:0] cfg_en,
    output logic [N_PINS-1:0] clr_vec
);

    // Update the addressed configuration register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_level <= '0;
            cfg_any   <= '0;
            cfg_pol   <= '0;
            cfg_en    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_LEVEL:  cfg_level <= wr_data;
                OFS_ANY:    cfg_any   <= wr_data;
                OFS_POL:    cfg_pol   <= wr_data;
                OFS_ENABLE: cfg_en    <= wr_data;
                default:    ;
            endcase
        end
    end

    // Turn a write to the clear offset into a per-pin clear request.
    always_comb begin
        clr_vec = '0;
        if (wr_en && (wr_addr == OFS_CLEAR)) begin
            clr_vec = wr_data;
        end
    end

endmodule

// File: rtl/pin_evt_detect.sv
// Module: per-pin detector. Keeps the previous pin levels and raises a
// set request for each pin whose configured edge or level condition holds
// in this cycle. Assumes pin inputs are already synchronous to clk.
module pin_evt_detect #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] pin_dir,
    input  logic [N_PINS-1:0] cfg_level,
    input  logic [N_PINS-1:0] cfg_any,
    input  logic [N_PINS-1:0] cfg_pol,
    output logic [N_PINS-1:0] set_vec
);

    logic [N_PINS-1:0] prev_q;

    // Remember the pin levels for the next cycle's edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        logic moved;
        logic pol_hit;
        logic edge_hit;

        // Evaluate this pin's edge and level conditions.
        always_comb begin
            moved    = (pin_in[g] != prev_q[g]) && !pin_dir[g];
            pol_hit  = (pin_in[g] == cfg_pol[g]);
            edge_hit = moved && (cfg_any[g] || pol_hit);
            set_vec[g] = cfg_level[g] ? pol_hit : edge_hit;
        end
    end

endmodule

// File: rtl/pin_evt_status.sv
// Module: sticky status vector with write-one-to-clear, where a
// simultaneous set wins. Also forms the masked view and the combined
// request line. Assumes set and clear vectors are valid each cycle.
module pin_evt_status #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] set_vec,
    input  logic [N_PINS-1:0] clr_vec,
    input  logic [N_PINS-1:0] cfg_en,
    output logic [N_PINS-1:0] raw_status,
    output logic [N_PINS-1:0] masked_status,
    output logic              irq
);

    // Hold detections until cleared; a new detection overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_status <= '0;
        else        raw_status <= (raw_status & ~clr_vec) | set_vec;
    end

    // Gate the raw bits by the enable vector and combine them.
    always_comb begin
        masked_status = raw_status & cfg_en;
        irq           = |masked_status;
    end

endmodule

// File: rtl/pin_event_irq.sv
// Module: top of the pin event interrupt detector. Ties together the
// configuration registers, the per-pin detector and the status vector.
// Assumes a write-only register bus and already-synchronous pins.
module pin_event_irq
    import pin_evt_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] pin_dir,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] raw_status,
    output logic [N_PINS-1:0] masked_status,
    output logic              irq
);

    logic [N_PINS-1:0] cfg_level;
    logic [N_PINS-1:0] cfg_any;
    logic [N_PINS-1:0] cfg_pol;
    logic [N_PINS-1:0] cfg_en;
    logic [N_PINS-1:0] clr_vec;
    logic [N_PINS-1:0] set_vec;

    pin_evt_cfg #(.N_PINS(N_PINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg_level (cfg_level),
        .cfg_any   (cfg_any),
        .cfg_pol   (cfg_pol),
        .cfg_en    (cfg_en),
        .clr_vec   (clr_vec)
    );

    pin_evt_detect #(.N_PINS(N_PINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pin_dir   (pin_dir),
        .cfg_level (cfg_level),
        .cfg_any   (cfg_any),
        .cfg_pol   (cfg_pol),
        .set_vec   (set_vec)
    );

    pin_evt_status #(.N_PINS(N_PINS)) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_vec       (set_vec),
        .clr_vec       (clr_vec),
        .cfg_en        (cfg_en),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .irq           (irq)
    );

endmodule

// File: rtl/pin_event_irq_chk.sv
// Module: property checker for the pin event interrupt detector, bound
// to the top. Observes ports plus the configuration and clear vectors.
module pin_event_irq_chk
    import pin_evt_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] pin_in,
    input logic [N_PINS-1:0] pin_dir,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [N_PINS-1:0] wr_data,
    input logic [N_PINS-1:0] raw_status,
    input logic [N_PINS-1:0] masked_status,
    input logic [N_PINS-1:0] cfg_level,
    input logic [N_PINS-1:0] cfg_any,
    input logic [N_PINS-1:0] cfg_pol,
    input logic [N_PINS-1:0] clr_vec
);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(raw_status) & ~raw_status & ~$past(clr_vec)) == '0));

    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(cfg_level & ~(pin_in ^ cfg_pol)) & ~raw_status) == '0));

    // R6
    out_pin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_status & ~$past(raw_status) & $past(pin_dir & ~cfg_level)) == '0));

    // R4
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_status & ~$past(raw_status)
                          & $past(~cfg_level & ~cfg_any & (pin_in ^ cfg_pol))) == '0));

    // R7
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_addr) == OFS_ENABLE))
        |-> (masked_status == (raw_status & $past(wr_data))));

endmodule

bind pin_event_irq pin_event_irq_chk #(.N_PINS(N_PINS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_in        (pin_in),
    .pin_dir       (pin_dir),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .cfg_level     (cfg_level),
    .cfg_any       (cfg_any),
    .cfg_pol       (cfg_pol),
    .clr_vec       (clr_vec)
);

// File: tb/test_pin_event_irq.sv
`timescale 1ns/1ps
// Bench: scoreboard for the pin event interrupt detector. A driver task
// applies one cycle of stimulus, predicts the result from the requirements
// and queues it; a monitor compares after each rising edge.
module test_pin_event_irq;

    localparam int NP = 8;
    localparam logic [11:0] A_LEVEL = 12'h404;
    localparam logic [11:0] A_ANY   = 12'h408;
    localparam logic [11:0] A_POL   = 12'h40C;
    localparam logic [11:0] A_EN    = 12'h410;
    localparam logic [11:0] A_CLR   = 12'h41C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_dir = '0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] raw_status;
    logic [NP-1:0] masked_status;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NP-1:0] raw;
        logic [NP-1:0] msk;
        logic          req;
        string         tag;
    } exp_t;

    exp_t sb[$];

    logic [NP-1:0] m_level = '0, m_any = '0, m_pol = '0, m_en = '0;
    logic [NP-1:0] m_prev = '0, m_raw = '0;

    always #2.5 clk = ~clk;

    pin_event_irq #(.N_PINS(NP)) i_pin_event_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .pin_dir       (pin_dir),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .irq           (irq)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (raw_status !== e.raw || masked_status !== e.msk || irq !== e.req) begin
            errors++;
            $display("FAIL %s: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
                     e.tag, raw_status, masked_status, irq, e.raw, e.msk, e.req);
        end
    endtask

    // Monitor: compare the oldest prediction just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) compare(sb.pop_front());
    end

    // Driver: one cycle of stimulus plus its predicted outcome.
    task automatic step(input logic [NP-1:0] pins, input logic [NP-1:0] dir,
                        input bit we, input logic [11:0] addr,
                        input logic [NP-1:0] data, input string tag);
        logic [NP-1:0] nraw;
        exp_t e;
        @(negedge clk);
        pin_in = pins; pin_dir = dir; wr_en = we; wr_addr = addr; wr_data = data;
        for (int i = 0; i < NP; i++) begin
            bit hit;
            bit clr;
            if (m_level[i]) hit = (pins[i] == m_pol[i]);
            else hit = !dir[i] && (pins[i] != m_prev[i]) && (m_any[i] || pins[i] == m_pol[i]);
            clr = we && (addr == A_CLR) && data[i];
            nraw[i] = hit || (m_raw[i] && !clr);
        end
        if (we) begin
            if (addr == A_LEVEL) m_level = data;
            if (addr == A_ANY)   m_any   = data;
            if (addr == A_POL)   m_pol   = data;
            if (addr == A_EN)    m_en    = data;
        end
        m_prev = pins;
        m_raw  = nraw;
        e.raw = nraw; e.msk = nraw & m_en; e.req = |(nraw & m_en); e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.raw = '0; r.msk = '0; r.req = 1'b0; r.tag = "R9 reset";
        compare(r);
        rst_n = 1'b1;
        // R1 configuration writes
        step(8'h00, 8'h00, 1, A_EN,  8'h0F, "R1 enable write");
        step(8'h00, 8'h00, 1, A_ANY, 8'h01, "R1 any-edge write");
        step(8'h00, 8'h00, 1, A_POL, 8'h02, "R1 polarity write");
        // R3 both edges on pin 0
        step(8'h01, 8'h00, 0, 12'h0, 8'h00, "R3 rise on any-edge pin");
        step(8'h01, 8'h00, 1, A_CLR, 8'h01, "R8 clear");
        step(8'h00, 8'h00, 0, 12'h0, 8'h00, "R3 fall on any-edge pin");
        step(8'h00, 8'h00, 1, A_CLR, 8'hFF, "R8 clear all");
        // R4 single edge: pin 1 rising, pin 3 falling
        step(8'h02, 8'h00, 0, 12'h0, 8'h00, "R4 rising edge sets");
        step(8'h02, 8'h00, 1, A_CLR, 8'h02, "R8 clear pin1");
        step(8'h00, 8'h00, 0, 12'h0, 8'h00, "R4 falling ignored on rising pin");
        step(8'h08, 8'h00, 0, 12'h0, 8'h00, "R4 rising ignored on falling pin");
        step(8'h00, 8'h00, 0, 12'h0, 8'h00, "R4 falling edge sets");
        step(8'h00, 8'h00, 1, A_CLR, 8'h08, "R8 clear pin3");
        // R6 output pin edges ignored
        step(8'h10, 8'h10, 0, 12'h0, 8'h00, "R6 output rise ignored");
        step(8'h00, 8'h10, 0, 12'h0, 8'h00, "R6 output fall ignored");
        // R2/R5 level mode on pin 5, active high
        step(8'h00, 8'h00, 1, A_POL,   8'h22, "R2 polarity for level");
        step(8'h00, 8'h00, 1, A_LEVEL, 8'h20, "R2 select level mode");
        step(8'h20, 8'h20, 0, 12'h0, 8'h00, "R5 level sets despite direction");
        step(8'h20, 8'h20, 1, A_CLR, 8'h20, "R5 clear under held level");
        step(8'h00, 8'h20, 1, A_CLR, 8'h20, "R5 clear after level drops");
        step(8'h20, 8'h20, 0, 12'h0, 8'h00, "R7 raw set but disabled");
        step(8'h20, 8'h20, 1, A_EN,  8'h20, "R7 enable raises irq");
        step(8'h00, 8'h20, 1, A_CLR, 8'h20, "R7 irq drops on clear");
        // R8 set wins over clear in the same cycle
        step(8'h01, 8'h00, 1, A_CLR, 8'h01, "R8 set wins rise");
        step(8'h01, 8'h00, 1, 12'h420, 8'hFF, "R1 unmapped write ignored");
        step(8'h00, 8'h00, 1, A_CLR, 8'hFF, "R8 set wins fall");
        step(8'h00, 8'h00, 1, A_CLR, 8'hFF, "R8 final clear");
        step(8'h01, 8'h00, 1, A_EN, 8'h01, "R1 unmapped write left config intact");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule